// File: doc/BRIEF.md
# Modem Handshake Control and Status Registers

This block is the modem handshake section of a serial port. A writable control register holds four handshake requests (terminal ready, request to send, and two general purpose outputs) and a loop-mode enable. It drives the four matching pins active low. While loop mode is on, the two general purpose outputs are held inactive.

A readable status byte reports the asserted state of four active-low modem inputs: clear to send, data set ready, ring indicator and carrier detect. It also carries one sticky change flag per input. Each input passes through a two-flop synchronizer and then an edge detector. The edge detector feeds a small per-input flag state machine.

Each flag machine has two states. `DS_CLEAR` moves to `DS_FLAGGED` when an event arrives. `DS_FLAGGED` returns to `DS_CLEAR` on a status read in a cycle with no new event. In all other cases the machine stays where it is. Reading the status clears the flags, and an interrupt request is raised while any flag is set and the modem-status interrupt enable is high. Register address decoding and interrupt prioritization belong to the surrounding port.

Top module: `modem_ctl_sts`

## Requirements
- R1: While `rst` is high, and after it is released, the control readback is 0x00, all four handshake pins are high, `loop_en` is 0, the status change bits 3:0 are 0 and `irq` is 0.
- R2: A write with `ctl_we` updates the control register on the clock edge. Bit 0 drives `dtr_n`, bit 1 drives `rts_n`, bit 2 drives `out1_n` and bit 3 drives `out2_n`. A 1 in a bit drives its pin low.
- R3: Control bit 4 enables loop mode and appears on `loop_en`. Control bits 7:5 are ignored on write and read back as 0.
- R4: While loop mode is on, `out1_n` and `out2_n` are high whatever control bits 2 and 3 hold. `dtr_n` and `rts_n` still follow bits 0 and 1.
- R5: Status bit 4 reports the asserted state of clear to send, bit 5 data set ready, bit 6 ring indicator and bit 7 carrier detect. A bit is 1 when its pin is low. It follows the pin two clock edges after the pin changes.
- R6: Status bits 0 (clear to send), 1 (data set ready) and 3 (carrier detect) are set on any change of their synchronized input, three clock edges after the pin changes. They stay set until a status read.
- R7: Status bit 2 is set only when the ring indicator pin goes from low to high. A high-to-low change leaves it clear.
- R8: During a `sts_rd` cycle, `sts_rdata` shows the flags as they stand. The flags then clear on the edge that ends the read.
- R9: A change event that lands in the same cycle as a status read leaves its flag set after the read.
- R10: `irq` is high exactly when `irq_en` is high and at least one of status bits 3:0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, active high, synchronous |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control register readback |
| sts_rd | input | 1 | Status read strobe; clears change flags |
| sts_rdata | output | 8 | Status byte |
| irq_en | input | 1 | Modem-status interrupt enable |
| irq | output | 1 | Modem-status interrupt request |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | General purpose output 1, active low |
| out2_n | output | 1 | General purpose output 2, active low |
| loop_en | output | 1 | Loop mode enable |

## Verification
The hardest case to reach is a change event that lands in exactly the cycle of a status read. That event is only visible inside the block, one cycle after the synchronizer output moves. The stimulus first sets the clear-to-send flag and then toggles the pin on a falling edge. It counts two falling edges to reach the event cycle and raises `sts_rd` there. The flag must still be set after the read.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int NUM_LINES = 4;
    localparam int IDX_CTS   = 0;
    localparam int IDX_DSR   = 1;
    localparam int IDX_RI    = 2;
    localparam int IDX_DCD   = 3;
    localparam int CTL_BITS  = 5;
    localparam int LOOP_BIT  = 4;

    typedef enum logic {
        DS_CLEAR   = 1'b0,
        DS_FLAGGED = 1'b1
    } dstate_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
    parameter int W       = 4,
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage[s] <= {W{RST_VAL}};
        end else begin
            stage[0] <= d;
            for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
        end
    end

    assign q = stage[STAGES-1];
endmodule

// File: rtl/mdm_delta_fsm.sv
module mdm_delta_fsm
    import mdm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic clr,
    output logic flag
);
    dstate_t state, state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= DS_CLEAR;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            DS_CLEAR:   if (evt)         state_nx = DS_FLAGGED;
            DS_FLAGGED: if (clr && !evt) state_nx = DS_CLEAR;
            default:                     state_nx = DS_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state == DS_FLAGGED);
    end
endmodule

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg
    import mdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       dtr_n,
    output logic       rts_n,
    output logic       out1_n,
    output logic       out2_n,
    output logic       loop_en
);
    localparam int PAD = 8 - CTL_BITS;

    logic [CTL_BITS-1:0] ctl_q;

    always_ff @(posedge clk) begin
        if (rst)     ctl_q <= '0;
        else if (we) ctl_q <= wdata[CTL_BITS-1:0];
    end

    always_comb begin
        loop_en = ctl_q[LOOP_BIT];
        rdata   = {{PAD{1'b0}}, ctl_q};
        dtr_n   = ~ctl_q[0];
        rts_n   = ~ctl_q[1];
        out1_n  = ~(ctl_q[2] & ~loop_en);
        out2_n  = ~(ctl_q[3] & ~loop_en);
    end
endmodule

// File: rtl/modem_ctl_sts.sv
module modem_ctl_sts
    import mdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctl_we,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    input  logic       sts_rd,
    output logic [7:0] sts_rdata,
    input  logic       irq_en,
    output logic       irq,
    input  logic       cts_n,
    input  logic       dsr_n,
    input  logic       ri_n,
    input  logic       dcd_n,
    output logic       dtr_n,
    output logic       rts_n,
    output logic       out1_n,
    output logic       out2_n,
    output logic       loop_en
);
    logic [NUM_LINES-1:0] pin_n, sync_n, prev_n, evt, flags;

    assign pin_n = {dcd_n, ri_n, dsr_n, cts_n};

    mdm_sync #(.W(NUM_LINES), .STAGES(2), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst(rst), .d(pin_n), .q(sync_n)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_n <= '1;
        else     prev_n <= sync_n;
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (i == IDX_RI) begin : g_trail
            assign evt[i] = sync_n[i] & ~prev_n[i];
        end else begin : g_any
            assign evt[i] = sync_n[i] ^ prev_n[i];
        end
        mdm_delta_fsm u_fsm (
            .clk(clk), .rst(rst), .evt(evt[i]), .clr(sts_rd), .flag(flags[i])
        );
    end

    assign sts_rdata = {~sync_n, flags};
    assign irq       = irq_en & (|flags);

    mdm_ctrl_reg u_ctrl (
        .clk(clk), .rst(rst), .we(ctl_we), .wdata(ctl_wdata),
        .rdata(ctl_rdata), .dtr_n(dtr_n), .rts_n(rts_n),
        .out1_n(out1_n), .out2_n(out2_n), .loop_en(loop_en)
    );
endmodule

// File: rtl/mdm_ctl_sts_chk.sv
module mdm_ctl_sts_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctl_we,
    input logic [7:0] ctl_wdata,
    input logic [7:0] ctl_rdata,
    input logic       sts_rd,
    input logic [7:0] sts_rdata,
    input logic       irq_en,
    input logic       irq,
    input logic       out1_n,
    input logic       out2_n,
    input logic       loop_en,
    input logic [3:0] evt
);
    p_ctl_zero_r1: assert property (@(posedge clk)
        rst |=> (ctl_rdata == 8'h00));

    p_write_r2: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> (ctl_rdata[4:0] == $past(ctl_wdata[4:0])));

    p_loop_out_r4: assert property (@(posedge clk) disable iff (rst)
        loop_en |-> (out1_n && out2_n));

    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (sts_rdata[0] && !sts_rd) |=> sts_rdata[0]);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (sts_rd && (evt == 4'b0000)) |=> (sts_rdata[3:0] == 4'b0000));

    p_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (sts_rd && evt[0]) |=> sts_rdata[0]);

    p_irq_off_r10: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);
endmodule

bind modem_ctl_sts mdm_ctl_sts_chk u_chk (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .sts_rd(sts_rd), .sts_rdata(sts_rdata),
    .irq_en(irq_en), .irq(irq), .out1_n(out1_n), .out2_n(out2_n),
    .loop_en(loop_en), .evt(evt)
);

// File: tb/tb_modem_ctl_sts.sv
module tb_modem_ctl_sts;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC      = 8;
    // {wdata[20:13], pins{out2_n,out1_n,rts_n,dtr_n}[12:9], rdata[8:1], loop[0]}
    localparam logic [20:0] VEC [N_VEC] = '{
        {8'h01, 4'b1110, 8'h01, 1'b0},
        {8'h02, 4'b1101, 8'h02, 1'b0},
        {8'h04, 4'b1011, 8'h04, 1'b0},
        {8'h08, 4'b0111, 8'h08, 1'b0},
        {8'hEF, 4'b0000, 8'h0F, 1'b0},
        {8'h1F, 4'b1100, 8'h1F, 1'b1},
        {8'h14, 4'b1111, 8'h14, 1'b1},
        {8'h00, 4'b1111, 8'h00, 1'b0}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic ctl_we = 1'b0, sts_rd = 1'b0, irq_en = 1'b0;
    logic [7:0] ctl_wdata = 8'h00;
    logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic [7:0] ctl_rdata, sts_rdata;
    logic irq, dtr_n, rts_n, out1_n, out2_n, loop_en;
    int n_chk = 0, n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    modem_ctl_sts dut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sts_rd(sts_rd), .sts_rdata(sts_rdata),
        .irq_en(irq_en), .irq(irq), .cts_n(cts_n), .dsr_n(dsr_n),
        .ri_n(ri_n), .dcd_n(dcd_n), .dtr_n(dtr_n), .rts_n(rts_n),
        .out1_n(out1_n), .out2_n(out2_n), .loop_en(loop_en)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic status_read();
        sts_rd = 1'b1;
        step(1);
        sts_rd = 1'b0;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(2);
        // R1 reset state
        chk("R1 ctl", ctl_rdata, 8'h00);
        chk("R1 pins", {out2_n, out1_n, rts_n, dtr_n, loop_en}, 5'b11110);
        chk("R1 sts", sts_rdata, 8'h00);
        chk("R1 irq", irq, 1'b0);

        // R2 R3 R4 control table
        for (int v = 0; v < N_VEC; v++) begin
            ctl_we = 1'b1;
            ctl_wdata = VEC[v][20:13];
            step(1);
            ctl_we = 1'b0;
            #1;
            chk("R2 R4 pins", {out2_n, out1_n, rts_n, dtr_n}, VEC[v][12:9]);
            chk("R3 readback", ctl_rdata, VEC[v][8:1]);
            chk("R3 loop", loop_en, VEC[v][0]);
        end

        // R5 R6 clear to send asserted
        cts_n = 1'b0;
        step(2);
        chk("R5 live cts", sts_rdata, 8'h10);
        step(1);
        chk("R6 delta cts", sts_rdata, 8'h11);
        chk("R10 irq disabled", irq, 1'b0);
        irq_en = 1'b1;
        #1;
        chk("R10 irq enabled", irq, 1'b1);
        sts_rd = 1'b1;
        #1;
        chk("R8 read shows flags", sts_rdata, 8'h11);
        step(1);
        sts_rd = 1'b0;
        #1;
        chk("R8 cleared", sts_rdata, 8'h10);
        chk("R10 irq after clear", irq, 1'b0);

        // R7 ring indicator falling pin: no flag
        ri_n = 1'b0;
        step(3);
        chk("R7 no flag on fall", sts_rdata, 8'h50);
        ri_n = 1'b1;
        step(3);
        chk("R7 flag on rise", sts_rdata, 8'h14);
        status_read();
        chk("R8 ri cleared", sts_rdata, 8'h10);

        // R6 data set ready and carrier detect
        dsr_n = 1'b0;
        dcd_n = 1'b0;
        step(3);
        chk("R6 dsr dcd set", sts_rdata, 8'hBA);
        status_read();
        chk("R8 dsr dcd cleared", sts_rdata, 8'hB0);
        dsr_n = 1'b1;
        step(3);
        chk("R6 dsr release", sts_rdata, 8'h92);
        status_read();
        chk("R8 cleared again", sts_rdata, 8'h90);

        // R9 event coincident with read
        cts_n = 1'b1;
        step(3);
        chk("R6 cts release", sts_rdata, 8'h81);
        cts_n = 1'b0;
        step(2);
        sts_rd = 1'b1;
        #1;
        chk("R9 read data", sts_rdata, 8'h91);
        step(1);
        sts_rd = 1'b0;
        #1;
        chk("R9 flag kept", sts_rdata, 8'h91);
        chk("R10 irq kept", irq, 1'b1);
        status_read();
        chk("R8 final clear", sts_rdata, 8'h90);

        // R1 reset mid-run
        ctl_we = 1'b1;
        ctl_wdata = 8'h03;
        step(1);
        ctl_we = 1'b0;
        cts_n = 1'b1;
        dcd_n = 1'b1;
        step(3);
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        #1;
        chk("R1 ctl after reset", ctl_rdata, 8'h00);
        chk("R1 pins after reset", {out2_n, out1_n, rts_n, dtr_n}, 4'b1111);
        chk("R1 sts after reset", sts_rdata, 8'h00);
        chk("R1 irq after reset", irq, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule